// File: doc/BRIEF.md
# Segmented Instruction Fetch Unit

This block keeps a byte queue of instruction code filled ahead of the consumer that executes it. A segment register and an offset pointer name the next code byte. The physical fetch address is the segment shifted up by four bit positions plus the offset, kept to 20 bits. Reads go out on a 16-bit memory path that is split into an even byte lane and an odd byte lane. Each read is either one aligned word or one single byte. The returned bytes are written into a small first-in first-out queue.

The consumer takes one byte per accepted pop. Refilling runs whenever the queue has room, without waiting for the consumer. A jump from the execution side loads a new segment and offset and empties the queue in the same cycle. If a read is still in flight at that time, its data is dropped when it returns.

The memory side uses a plain request/grant handshake with a separate read-valid strobe. At most one read is outstanding at any time. A request keeps its address and lane choice until it is granted.

Top module: `seg_fetch_unit`

## Requirements
- R1: Every fetch request presents mem_addr = (segment × 16 + offset) mod 2^20.
- R2: During reset the queue is empty (pop_valid low). The segment resets to 0xFFFF and the offset to 0x0000, so the first request after reset is at 0xFFFF0.
- R3: The queue never holds more than QDEPTH (6) bytes, and no request is raised while it is full.
- R4: A word fetch is made only when the offset is even and at least two slots are free. It drives mem_addr[0]=0 and mem_odd_en_n=0. The byte at the even address arrives on mem_rdata[7:0] and is queued first; the byte at the odd address arrives on mem_rdata[15:8] and is queued second.
- R5: Every other fetch is a single byte. An odd offset drives mem_addr[0]=1 and mem_odd_en_n=0, and the byte is taken from mem_rdata[15:8]. An even offset with only one free slot drives mem_addr[0]=0 and mem_odd_en_n=1, and the byte is taken from mem_rdata[7:0].
- R6: After each granted fetch, the offset advances by the number of bytes fetched, modulo 2^16. The segment does not change.
- R7: The k-th byte popped after a jump (or after reset) is the memory byte at segment:(offset+k), with the offset sum taken modulo 2^16.
- R8: pop_valid is high exactly when the queue holds at least one byte. A pop and a refill may complete in the same cycle, and neither is lost.
- R9: In a cycle with jmp_valid high, no request is raised and any pop is ignored. In the next cycle pop_valid is low, and later requests start at the new segment:offset.
- R10: Data returned for a read that was in flight at a jump, or that returns in the jump cycle, is never queued.
- R11: At most one read is outstanding. An ungranted request holds its address and lane enables until it is granted or a jump occurs. While the queue has room and no read is outstanding, a request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| jmp_valid | input | 1 | Jump: flush the queue and load a new segment and offset |
| jmp_seg | input | 16 | Segment loaded on a jump |
| jmp_off | input | 16 | Offset loaded on a jump |
| mem_req | output | 1 | Read request |
| mem_gnt | input | 1 | Request accepted in this cycle |
| mem_addr | output | 20 | Physical read address; bit 0 low enables the even lane |
| mem_odd_en_n | output | 1 | Odd lane enable, active low |
| mem_rvalid | input | 1 | Read data valid for the outstanding read |
| mem_rdata | input | 16 | Read data; [7:0] even lane, [15:8] odd lane |
| pop_valid | output | 1 | Queue head holds a byte |
| pop_ready | input | 1 | Consumer takes the head byte |
| pop_data | output | 8 | Head byte of the queue |

## Verification
The bench builds the block with its default parameters: a six-byte queue and 16-bit segment and offset registers. At this size every occupancy from empty to full is reached within a few cycles. It also lets a sweep of jump targets cover every offset residue near the top of the 64 KB window.

Grant delay, response latency and consumer readiness are varied by a pseudo-random sequence. This brings in-flight discards at a jump, jumps in the same cycle as a response, single-slot even-byte fetches, physical address wrap past 0xFFFFF and offset wrap past 0xFFFF within reach.

// File: rtl/fu_pkg.sv
// Shared definitions for the segmented fetch unit.
// Assumes a two-lane (even/odd) byte memory path.
package fu_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;

    // Shape of the read currently in flight
    typedef enum logic [1:0] {
        FK_WORD = 2'd0,   // both lanes, two bytes
        FK_EVEN = 2'd1,   // low lane only
        FK_ODD  = 2'd2    // high lane only
    } fetch_kind_e;
endpackage

// File: rtl/fu_addr_gen.sv
// Physical address former: segment shifted by SHIFT plus offset.
// The sum wraps to PA_W bits. Assumes OFF_W <= PA_W.
module fu_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  phys
);
    logic [PA_W-1:0] seg_base;
    logic [PA_W-1:0] off_ext;

    // Combinational: align the segment, zero-extend the offset, add modulo 2^PA_W
    always_comb begin
        seg_base = {seg, {SHIFT{1'b0}}};
        off_ext  = PA_W'(off);
        phys     = seg_base + off_ext;
    end
endmodule

// File: rtl/fu_byte_queue.sv
// Byte FIFO of DEPTH entries.
// Accepts 0, 1 or 2 bytes per cycle and releases at most one.
// Assumes the caller never pushes past DEPTH and never pops when empty.
// A flush empties it in one cycle and drops any push in that cycle.
module fu_byte_queue #(
    parameter int DEPTH = 6,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [1:0]    push_n,
    input  logic [7:0]    push_b0,
    input  logic [7:0]    push_b1,
    input  logic          pop,
    output logic [LW-1:0] level,
    output logic [7:0]    head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW-1:0] rd_p, wr_p, wr_p1;
    logic [7:0]    slot [DEPTH];

    function automatic logic [PW-1:0] ring_step(input logic [PW-1:0] p, input int k);
        int s;
        s = int'(p) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return PW'(s);
    endfunction

    // Combinational: second write position and head byte
    always_comb begin
        wr_p1 = ring_step(wr_p, 1);
        head  = slot[rd_p];
    end

    // Storage: write the incoming bytes into their slots
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!flush && push_n != 2'd0 && wr_p == PW'(i))
                slot[i] <= push_b0;
            else if (!flush && push_n == 2'd2 && wr_p1 == PW'(i))
                slot[i] <= push_b1;
        end
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_p  <= '0;
            wr_p  <= '0;
            level <= '0;
        end else begin
            wr_p  <= ring_step(wr_p, int'(push_n));
            if (pop) rd_p <= ring_step(rd_p, 1);
            level <= level + LW'(push_n) - LW'(pop);
        end
    end
endmodule

// File: rtl/fu_fetch_ctrl.sv
// Fetch sequencer.
// Holds the segment and offset and picks word or byte reads from queue room
// and offset parity. Keeps one read outstanding, and steers returned lanes
// into queue pushes. Marks an in-flight read stale on a jump.
// Assumes mem_rvalid arrives only for a granted read.
module fu_fetch_ctrl
    import fu_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int DEPTH = 6,
    parameter int LW    = $clog2(DEPTH + 1),
    parameter logic [SEG_W-1:0] RST_SEG = '1,
    parameter logic [OFF_W-1:0] RST_OFF = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             jmp_valid,
    input  logic [SEG_W-1:0] jmp_seg,
    input  logic [OFF_W-1:0] jmp_off,
    input  logic [LW-1:0]    level,
    input  logic             mem_gnt,
    input  logic             mem_rvalid,
    input  logic [15:0]      mem_rdata,
    output logic [SEG_W-1:0] seg,
    output logic [OFF_W-1:0] off,
    output logic             req,
    output logic             odd_en_n,
    output logic [1:0]       push_n,
    output logic [7:0]       push_b0,
    output logic [7:0]       push_b1,
    output logic             busy
);
    logic        held_valid, held_word;
    logic        stale;
    fetch_kind_e kind, kind_next;
    logic        word_sel, room2, grant, accept;

    // Combinational: request shape, handshake and lane steering
    always_comb begin
        room2     = (int'(level) + 2 <= DEPTH);
        word_sel  = held_valid ? held_word : (!off[0] && room2);
        req       = !busy && !jmp_valid && (int'(level) < DEPTH);
        odd_en_n  = !(word_sel || off[0]);
        kind_next = word_sel ? FK_WORD : (off[0] ? FK_ODD : FK_EVEN);
        grant     = req && mem_gnt;
        accept    = busy && mem_rvalid && !stale && !jmp_valid;
        push_n    = accept ? ((kind == FK_WORD) ? 2'd2 : 2'd1) : 2'd0;
        push_b0   = (kind == FK_ODD) ? mem_rdata[15:8] : mem_rdata[7:0];
        push_b1   = mem_rdata[15:8];
    end

    // Segment and offset: load on jump, advance on grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg <= RST_SEG;
            off <= RST_OFF;
        end else if (jmp_valid) begin
            seg <= jmp_seg;
            off <= jmp_off;
        end else if (grant) begin
            off <= off + OFF_W'(word_sel ? 2 : 1);
        end
    end

    // Outstanding read tracking and stale marking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            stale <= 1'b0;
            kind  <= FK_WORD;
        end else if (grant) begin
            busy  <= 1'b1;
            stale <= 1'b0;
            kind  <= kind_next;
        end else if (busy && mem_rvalid) begin
            busy  <= 1'b0;
            stale <= 1'b0;
        end else if (jmp_valid && busy) begin
            stale <= 1'b1;
        end
    end

    // Hold the lane choice of an ungranted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_valid <= 1'b0;
            held_word  <= 1'b0;
        end else begin
            held_valid <= req && !mem_gnt;
            held_word  <= word_sel;
        end
    end
endmodule

// File: rtl/seg_fetch_unit.sv
// Top of the segmented fetch unit.
// Joins the fetch sequencer, the address former and the byte queue.
// Assumes a memory that grants requests and returns exactly one response per grant.
module seg_fetch_unit
    import fu_pkg::*;
#(
    parameter int QDEPTH = 6,
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter logic [SEG_W-1:0] RST_SEG = 16'hFFFF,
    parameter logic [OFF_W-1:0] RST_OFF = 16'h0000,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             jmp_valid,
    input  logic [SEG_W-1:0] jmp_seg,
    input  logic [OFF_W-1:0] jmp_off,
    output logic             mem_req,
    input  logic             mem_gnt,
    output logic [PA_W-1:0]  mem_addr,
    output logic             mem_odd_en_n,
    input  logic             mem_rvalid,
    input  logic [15:0]      mem_rdata,
    output logic             pop_valid,
    input  logic             pop_ready,
    output logic [7:0]       pop_data
);
    localparam int LW = $clog2(QDEPTH + 1);

    logic [SEG_W-1:0] cur_seg;
    logic [OFF_W-1:0] cur_off;
    logic [LW-1:0]    q_level;
    logic [1:0]       push_n;
    logic [7:0]       push_b0, push_b1;
    logic             fetch_busy;
    logic             pop_fire;

    // Combinational: consumer handshake, with the flush taking priority
    always_comb begin
        pop_valid = (q_level != '0);
        pop_fire  = pop_valid && pop_ready && !jmp_valid;
    end

    fu_fetch_ctrl #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .DEPTH(QDEPTH), .LW(LW),
        .RST_SEG(RST_SEG), .RST_OFF(RST_OFF)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .jmp_valid(jmp_valid), .jmp_seg(jmp_seg), .jmp_off(jmp_off),
        .level(q_level),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .seg(cur_seg), .off(cur_off),
        .req(mem_req), .odd_en_n(mem_odd_en_n),
        .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1),
        .busy(fetch_busy)
    );

    fu_addr_gen #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)
    ) u_addr (
        .seg(cur_seg), .off(cur_off), .phys(mem_addr)
    );

    fu_byte_queue #(
        .DEPTH(QDEPTH), .LW(LW)
    ) u_queue (
        .clk(clk), .rst_n(rst_n), .flush(jmp_valid),
        .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1),
        .pop(pop_fire), .level(q_level), .head(pop_data)
    );
endmodule

// File: rtl/fu_fetch_checker.sv
// Protocol and occupancy properties of the segmented fetch unit.
// Attached to every seg_fetch_unit instance by the bind below.
module fu_fetch_checker #(
    parameter int QDEPTH = 6,
    parameter int PA_W   = 20,
    parameter int LW     = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            jmp_valid,
    input logic            mem_req,
    input logic            mem_gnt,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_odd_en_n,
    input logic            pop_valid,
    input logic [LW-1:0]   q_level,
    input logic            fetch_busy
);
    // R3: occupancy bound
    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_level) <= QDEPTH);

    // R3: no request while full
    a_r3_no_req_full: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q_level) == QDEPTH) |-> !mem_req);

    // R4: a two-lane read needs two free slots
    a_r4_word_room: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_addr[0] && !mem_odd_en_n) |-> (int'(q_level) + 2 <= QDEPTH));

    // R5: an odd address always enables the odd lane
    a_r5_odd_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_addr[0]) |-> !mem_odd_en_n);

    // R9: a jump leaves the queue empty
    a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_valid |=> !pop_valid);

    // R9: no request in a jump cycle
    a_r9_quiet_jump: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_valid |-> !mem_req);

    // R11: one read outstanding
    a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_busy |-> !mem_req);

    // R11: an ungranted request holds its address and lanes
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (jmp_valid ||
            (mem_req && $stable(mem_addr) && $stable(mem_odd_en_n))));
endmodule

bind seg_fetch_unit fu_fetch_checker #(
    .QDEPTH(QDEPTH), .PA_W(PA_W), .LW(LW)
) u_fetch_chk (
    .clk(clk), .rst_n(rst_n), .jmp_valid(jmp_valid),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .mem_odd_en_n(mem_odd_en_n), .pop_valid(pop_valid),
    .q_level(q_level), .fetch_busy(fetch_busy)
);

// File: tb/tb_seg_fetch_unit.sv
// Self-checking bench for seg_fetch_unit with default parameters.
module tb_seg_fetch_unit;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PERIOD = 10;
    localparam int QD = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        jmp_valid = 1'b0;
    logic [15:0] jmp_seg = '0;
    logic [15:0] jmp_off = '0;
    logic        mem_req;
    logic        mem_gnt = 1'b0;
    logic [19:0] mem_addr;
    logic        mem_odd_en_n;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        pop_valid;
    logic        pop_ready = 1'b0;
    logic [7:0]  pop_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_fetch_unit dut (
        .clk(clk), .rst_n(rst_n),
        .jmp_valid(jmp_valid), .jmp_seg(jmp_seg), .jmp_off(jmp_off),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
        .mem_odd_en_n(mem_odd_en_n),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data)
    );

    int total = 0;
    int bad = 0;

    // Bench model state
    logic [15:0] m_seg = 16'hFFFF;
    logic [15:0] m_pop_off = 16'h0000;
    logic [15:0] m_req_off = 16'h0000;
    int          m_cnt = 0;
    bit          m_held = 0, m_hw = 0, m_busy = 0, m_pend = 0;
    int          m_timer = 0, m_gen = 0, r_gen = 0;
    logic [19:0] r_addr = '0;
    bit          r_word = 0;
    bit          first_req = 1;
    logic [15:0] lf = 16'hACE1;

    function automatic logic [7:0] mbyte(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h0} ^ 8'h3C;
    endfunction

    function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock of stimulus and checking; rmode 0 stall, 1 always ready, 2 pseudo-random
    task automatic step(input bit jmp, input logic [15:0] js, input logic [15:0] jo, input int rmode);
        bit deliver;
        bit rdy;
        @(negedge clk);
        deliver    = 0;
        mem_rvalid = 1'b0;
        mem_rdata  = 16'h0000;
        if (m_pend) begin
            if (m_timer == 0) begin
                deliver    = 1;
                mem_rvalid = 1'b1;
                if (r_word)         mem_rdata = {mbyte(r_addr | 20'h1), mbyte(r_addr)};
                else if (r_addr[0]) mem_rdata = {mbyte(r_addr), 8'hEE};
                else                mem_rdata = {8'hEE, mbyte(r_addr)};
            end else begin
                m_timer--;
            end
        end
        jmp_valid = jmp;
        jmp_seg   = js;
        jmp_off   = jo;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        rdy = !jmp && (rmode == 1 || (rmode == 2 && lf[0]));
        pop_ready = rdy;
        #1;
        // R8: valid flag follows occupancy
        chk(pop_valid == (m_cnt != 0), "R8 pop_valid vs occupancy", 32'(pop_valid), 32'(m_cnt != 0));
        if (jmp) chk(!mem_req, "R9 request in jump cycle", 32'(mem_req), 0);
        if (mem_req && !jmp) begin
            chk(!m_busy, "R11 second outstanding read", 32'(m_busy), 0);
            chk(m_cnt < QD, "R3 request while full", 32'(m_cnt), QD - 1);
            if (!m_held) m_hw = !m_req_off[0] && (QD - m_cnt) >= 2;
            chk(mem_addr == pa(m_seg, m_req_off), "R1 R6 fetch address",
                32'(mem_addr), 32'(pa(m_seg, m_req_off)));
            if (first_req) begin
                chk(mem_addr == 20'hFFFF0, "R2 first address after reset", 32'(mem_addr), 32'hFFFF0);
                first_req = 0;
            end
            if (m_hw)
                chk(!mem_addr[0] && !mem_odd_en_n, "R4 word lane enables",
                    {30'h0, mem_addr[0], mem_odd_en_n}, 0);
            else if (m_req_off[0])
                chk(mem_addr[0] && !mem_odd_en_n, "R5 odd byte enables",
                    {30'h0, mem_addr[0], mem_odd_en_n}, 2);
            else
                chk(!mem_addr[0] && mem_odd_en_n, "R5 even byte enables",
                    {30'h0, mem_addr[0], mem_odd_en_n}, 1);
            mem_gnt = (lf[2:1] != 2'b00);
            if (mem_gnt) begin
                m_pend    = 1;
                m_busy    = 1;
                m_timer   = int'(lf[4:3]) % 3;
                r_addr    = mem_addr;
                r_word    = m_hw;
                r_gen     = m_gen;
                m_req_off = m_req_off + (m_hw ? 16'd2 : 16'd1);
                m_held    = 0;
            end else begin
                m_held = 1;
            end
        end else begin
            mem_gnt = 1'b0;
            if (!jmp)
                chk(!(!m_busy && m_cnt < QD), "R11 R3 request presence",
                    32'(mem_req), 32'(!m_busy && m_cnt < QD));
        end
        if (jmp) begin
            m_gen++;
            m_seg     = js;
            m_req_off = jo;
            m_pop_off = jo;
            m_cnt     = 0;
            m_held    = 0;
        end
        if (deliver) begin
            m_pend = 0;
            m_busy = 0;
            if (r_gen == m_gen) m_cnt += (r_word ? 2 : 1);
        end
        if (pop_valid && rdy) begin
            // R7 order, R10 stale data never appears
            chk(pop_data == mbyte(pa(m_seg, m_pop_off)), "R7 R10 popped byte",
                32'(pop_data), 32'(mbyte(pa(m_seg, m_pop_off))));
            m_pop_off = m_pop_off + 16'd1;
            m_cnt--;
        end
    endtask

    task automatic run(input int n, input int rmode);
        for (int i = 0; i < n; i++) step(0, 16'h0, 16'h0, rmode);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R2: reset state
        repeat (3) begin
            @(negedge clk);
            #1;
            chk(!pop_valid, "R2 queue empty in reset", 32'(pop_valid), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1 physical wrap: 0xFFFF0 + 16 passes 0xFFFFF
        run(200, 2);
        // Odd target, offset wrap, physical wrap, near-zero target
        step(1, 16'h1234, 16'h0007, 2); run(150, 2);
        step(1, 16'h0100, 16'hFFFB, 2); run(150, 2);
        step(1, 16'hFFFF, 16'hFFFD, 1); run(150, 1);
        // R5 even single-slot path: fill from an odd offset with the consumer stalled
        step(1, 16'h0000, 16'h0001, 0); run(40, 0);
        run(60, 1);
        // R9 R10: sweep of jumps landing while reads are in flight
        for (int s = 0; s < 16; s++) begin
            step(1, 16'hABCD, 16'hFFF0 + 16'(s), 2);
            run(s % 5, 2);
            step(1, 16'h4000 + 16'(s), 16'hFFF8 + 16'(s), 2);
            run(50, (s % 3 == 0) ? 1 : 2);
        end
        // Back-to-back jumps
        for (int s = 0; s < 8; s++) step(1, 16'h0F00, 16'(s * 3), 2);
        run(80, 2);
        finish_run();
    end
endmodule